// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

The decoder maps a 4 KiB page number to one of eight chip-select rows of DRAM. Each row owns an 8-bit boundary register. The register holds the running total of installed memory up to and including that row, so the highest row's register equals the total memory size. A granularity field in the controller-mode word sets the size of one boundary step. The step is 32 MiB shifted left by the field value. The lookup is combinational: the row index and the hit flag follow `page_i` within the same cycle.

For every row the block also reports three things: whether the row is populated, whether it is built from x4 or x8 devices, and which ECC scheme covers it. The ECC scheme depends on three inputs: the ECC enable field, the channel-count bit and the row's device width. Software loads the eight boundaries, the row-attribute word and the controller-mode word through a plain write strobe. A write becomes visible in the cycle after the clock edge that captures it.

Top module: `row_boundary_decoder`

## Requirements
- R1: After reset every boundary, the attribute word and the mode word are zero. `populated_o`, `x4_o` and `ecc_mode_o` then read zero, and `hit_o` is 0 for every page.
- R2: A write with `wr_en_i` high loads a register at the next rising clock edge, selected by `wr_addr_i`:
  - addresses 0 to 7 load the boundary of that row from `wr_data_i[7:0]`;
  - address 8 loads the attribute word;
  - address 9 loads the mode word;
  - addresses 10 to 15 change no output.
- R3: The boundary of row i, expressed in pages, is B_i shifted left by (13 + G). G is the mode word's bits 19:18 and takes the values 0 to 3.
- R4: `populated_o[i]` is 1 exactly when B_i differs from B_(i-1). B_(-1) is taken as 0.
- R5: A page P hits row i when P is at least the page boundary of row i-1 (0 for row 0) and below the page boundary of row i. When more than one row satisfies this, the lowest such index wins.
- R6: A page at or above the page boundary of row 7 gives `hit_o`=0 and `row_o`=0. Any miss gives `row_o`=0.
- R7: An unpopulated row is never reported as a hit.
- R8: `x4_o[i]` equals bit 4*i+3 of the attribute word. A value of 1 means x4 devices and 0 means x8 devices.
- R9: `ecc_mode_o[2i+1:2i]` gives the ECC scheme of row i, using mode word bit 22 (1 = dual channel) and the ECC field in bits 21:20:
  - 0 (none) when the ECC field is zero;
  - 2 (four-bit symbol correct, double symbol detect) when the controller is dual channel and the row uses x4 devices;
  - 1 (single-error correct, double-error detect) in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register select |
| wr_data_i | input | 32 | Write data |
| page_i | input | 22 | Page number to look up, 4 KiB units |
| row_o | output | 3 | Matching row index |
| hit_o | output | 1 | Page falls in a populated row |
| populated_o | output | 8 | Per-row populated flags |
| x4_o | output | 8 | Per-row device width, 1 = x4 |
| ecc_mode_o | output | 16 | Per-row ECC scheme, 2 bits per row |

## Verification
Several boundary sets are loaded under every granularity value:
- strictly increasing boundaries;
- boundaries with empty rows in the middle;
- boundaries with empty leading rows and a full-scale top boundary;
- all-zero boundaries.

Lookups probe each page boundary one page below, on and one page above it, plus the first and the highest page. These probes separate an off-by-one at a row edge, a wrong granularity shift and an empty row that wrongly matches. Changing the mode and attribute words between configurations covers every combination of ECC enable, channel count and device width. A write to an unused address checks that no output moves.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [1:0] {
    ECC_NONE     = 2'd0,
    ECC_SECDED   = 2'd1,
    ECC_S4ECD4ED = 2'd2
  } ecc_mode_e;

  localparam int unsigned GRAN_W         = 2;
  localparam int unsigned GRAN_LSB       = 18;
  localparam int unsigned ECC_LSB        = 20;
  localparam int unsigned DUAL_BIT       = 22;
  localparam int unsigned ATTR_STRIDE    = 4;
  localparam int unsigned ATTR_X4_OFS    = 3;
  localparam int unsigned UNIT_SHIFT     = 13;  // 32 MiB in 4 KiB pages
  localparam int unsigned GRAN_MAX_SHIFT = 3;
endpackage

// File: rtl/rbd_regs.sv
module rbd_regs
  import rbd_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 8,
  parameter int unsigned BND_W    = 8,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_ROWS + 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]         wr_data_i,
  output logic [NUM_ROWS*BND_W-1:0] bnd_o,
  output logic [NUM_ROWS-1:0]       x4_o,
  output logic [GRAN_W-1:0]         gran_o,
  output logic [1:0]                ecc_fld_o,
  output logic                      dual_o
);
  localparam logic [ADDR_W-1:0] ATTR_ADDR = ADDR_W'(NUM_ROWS);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_ROWS + 1);

  logic unused_wdata;
  assign unused_wdata = ^wr_data_i;

  // only the fields that downstream logic decodes are kept
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [BND_W-1:0] bnd_q;
    logic             x4_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bnd_q <= '0;
        x4_q  <= 1'b0;
      end else if (wr_en_i) begin
        if (wr_addr_i == ADDR_W'(i)) bnd_q <= wr_data_i[BND_W-1:0];
        if (wr_addr_i == ATTR_ADDR)  x4_q  <= wr_data_i[ATTR_STRIDE*i + ATTR_X4_OFS];
      end
    end
    assign bnd_o[i*BND_W +: BND_W] = bnd_q;
    assign x4_o[i] = x4_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gran_o    <= '0;
      ecc_fld_o <= '0;
      dual_o    <= 1'b0;
    end else if (wr_en_i && wr_addr_i == MODE_ADDR) begin
      gran_o    <= wr_data_i[GRAN_LSB +: GRAN_W];
      ecc_fld_o <= wr_data_i[ECC_LSB +: 2];
      dual_o    <= wr_data_i[DUAL_BIT];
    end
  end
endmodule

// File: rtl/rbd_row_attr.sv
module rbd_row_attr
  import rbd_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 8,
  parameter int unsigned BND_W    = 8
) (
  input  logic [NUM_ROWS*BND_W-1:0] bnd_i,
  input  logic [NUM_ROWS-1:0]       x4_i,
  input  logic [1:0]                ecc_fld_i,
  input  logic                      dual_i,
  output logic [NUM_ROWS-1:0]       populated_o,
  output logic [2*NUM_ROWS-1:0]     ecc_mode_o
);
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [BND_W-1:0] prev;
    ecc_mode_e        mode;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = bnd_i[(i-1)*BND_W +: BND_W];
    end
    assign populated_o[i] = bnd_i[i*BND_W +: BND_W] != prev;

    always_comb begin
      if (ecc_fld_i == 2'b00)      mode = ECC_NONE;
      else if (dual_i && x4_i[i])  mode = ECC_S4ECD4ED;
      else                         mode = ECC_SECDED;
    end
    assign ecc_mode_o[2*i +: 2] = mode;
  end
endmodule

// File: rtl/rbd_lookup.sv
module rbd_lookup
  import rbd_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 8,
  parameter int unsigned BND_W    = 8,
  parameter int unsigned PAGE_W   = 22,
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic [NUM_ROWS*BND_W-1:0] bnd_i,
  input  logic [GRAN_W-1:0]         gran_i,
  input  logic [PAGE_W-1:0]         page_i,
  output logic [ROW_W-1:0]          row_o,
  output logic                      hit_o
);
  localparam int unsigned PG_W  = BND_W + UNIT_SHIFT + GRAN_MAX_SHIFT;
  localparam int unsigned CMP_W = (PG_W > PAGE_W) ? PG_W : PAGE_W;
  localparam int unsigned SHW   = $clog2(CMP_W + 1);

  logic [CMP_W-1:0]    pg;
  logic [CMP_W-1:0]    bpage [NUM_ROWS];
  logic [NUM_ROWS-1:0] match;
  logic [SHW-1:0]      shamt;

  assign pg    = CMP_W'(page_i);
  assign shamt = SHW'(UNIT_SHIFT) + SHW'(gran_i);

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_cmp
    assign bpage[i] = CMP_W'(bnd_i[i*BND_W +: BND_W]) << shamt;
    // empty rows give an empty window, so they never match
    if (i == 0) begin : g_first
      assign match[i] = pg < bpage[i];
    end else begin : g_rest
      assign match[i] = (pg >= bpage[i-1]) && (pg < bpage[i]);
    end
  end

  always_comb begin
    row_o = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (match[i]) row_o = ROW_W'(i);
    end
    hit_o = (|match) && (pg < bpage[NUM_ROWS-1]);
    if (!hit_o) row_o = '0;
  end
endmodule

// File: rtl/row_boundary_decoder.sv
module row_boundary_decoder
  import rbd_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 8,
  parameter int unsigned BND_W    = 8,
  parameter int unsigned PAGE_W   = 22,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_ROWS + 2),
  localparam int unsigned ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [PAGE_W-1:0]     page_i,
  output logic [ROW_W-1:0]      row_o,
  output logic                  hit_o,
  output logic [NUM_ROWS-1:0]   populated_o,
  output logic [NUM_ROWS-1:0]   x4_o,
  output logic [2*NUM_ROWS-1:0] ecc_mode_o
);
  logic [NUM_ROWS*BND_W-1:0] bnd;
  logic [GRAN_W-1:0]         gran;
  logic [1:0]                ecc_fld;
  logic                      dual;

  rbd_regs #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .bnd_o(bnd), .x4_o, .gran_o(gran), .ecc_fld_o(ecc_fld), .dual_o(dual)
  );

  rbd_row_attr #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W)) u_attr (
    .bnd_i(bnd), .x4_i(x4_o), .ecc_fld_i(ecc_fld), .dual_i(dual),
    .populated_o, .ecc_mode_o
  );

  rbd_lookup #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .PAGE_W(PAGE_W)) u_lookup (
    .bnd_i(bnd), .gran_i(gran), .page_i, .row_o, .hit_o
  );

  AST_MISS_ROW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> row_o == '0);  // R6
  AST_HIT_POPULATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> populated_o[row_o]);  // R7
  AST_ECC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_fld == 2'b00 |-> ecc_mode_o == '0);  // R9
  AST_IGNORED_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_addr_i) > NUM_ROWS + 1) |=>
      ($stable(populated_o) && $stable(x4_o) && $stable(ecc_mode_o)));  // R2
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_ast
    AST_S4_NEEDS_DUAL_X4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ecc_mode_o[2*i +: 2] == 2'd2 |-> (dual && x4_o[i]));  // R9
  end
endmodule

// File: tb/row_boundary_decoder_bench.sv
`timescale 1ns/1ps
module row_boundary_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [21:0] page_i = '0;
  logic [2:0]  row_o;
  logic        hit_o;
  logic [7:0]  populated_o, x4_o;
  logic [15:0] ecc_mode_o;

  int n_checks = 0;
  int n_fail   = 0;
  int bnd [8];
  int gran;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  row_boundary_decoder u_row_boundary_decoder (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .page_i,
    .row_o, .hit_o, .populated_o, .x4_o, .ecc_mode_o
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 4'(addr); wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic void model(input longint pg, output int row, output bit hit);
    longint lo, hi, top;
    row = 0; hit = 0; lo = 0;
    top = longint'(bnd[7]) << (13 + gran);
    for (int i = 0; i < 8; i++) begin
      hi = longint'(bnd[i]) << (13 + gran);
      if (!hit && pg >= lo && pg < hi && pg < top) begin hit = 1; row = i; end
      lo = hi;
    end
  endfunction

  task automatic probe(input longint pg);
    int  er;
    bit  eh;
    if (pg < 0 || pg > 22'h3fffff) return;
    model(pg, er, eh);
    page_i = 22'(pg);
    #1;
    chk(eh ? "R5 hit" : "R6/R7 miss", hit_o, eh);
    chk("R5/R6 row", row_o, er);
  endtask

  task automatic run_cfg(input int b0, b1, b2, b3, b4, b5, b6, b7,
                         input logic [31:0] attr, input int dual, input int ecc);
    logic [31:0] mode;
    int prev, exp_e;
    bnd = '{b0, b1, b2, b3, b4, b5, b6, b7};
    for (int g = 0; g < 4; g++) begin
      gran = g;
      for (int i = 0; i < 8; i++) wr(i, 32'(bnd[i]) | 32'hffff_ff00);
      wr(8, attr);
      mode = '0;
      mode[19:18] = 2'(g);
      mode[21:20] = 2'((ecc + g) % 4);
      mode[22]    = 1'(dual);
      wr(9, mode);
      #1;
      prev = 0;
      for (int i = 0; i < 8; i++) begin
        chk("R4 populated", populated_o[i], bnd[i] != prev);
        prev = bnd[i];
        chk("R8 width", x4_o[i], attr[4*i+3]);
        if (mode[21:20] == 2'b00) exp_e = 0;
        else if (dual != 0 && attr[4*i+3]) exp_e = 2;
        else exp_e = 1;
        chk("R9 ecc", ecc_mode_o[2*i +: 2], exp_e);
      end
      probe(0);
      probe(22'h3fffff);
      for (int i = 0; i < 8; i++) begin
        longint bp = longint'(bnd[i]) << (13 + g);  // R3 page scale
        probe(bp - 1);
        probe(bp);
        probe(bp + 1);
      end
    end
    // R2: unused addresses must not disturb anything
    begin
      logic [7:0]  p0 = populated_o, x0 = x4_o;
      logic [15:0] e0 = ecc_mode_o;
      wr(12, 32'hffff_ffff);
      wr(15, 32'h0);
      #1;
      chk("R2 ignored populated", populated_o, p0);
      chk("R2 ignored width", x4_o, x0);
      chk("R2 ignored ecc", ecc_mode_o, e0);
      probe(longint'(bnd[3]) << 16);
    end
  endtask

  initial begin
    rst_ni = 1'b0;
    #12;
    // R1 reset state
    chk("R1 populated", populated_o, 0);
    chk("R1 width", x4_o, 0);
    chk("R1 ecc", ecc_mode_o, 0);
    page_i = 22'd5; #1;
    chk("R1 hit", hit_o, 0);
    chk("R1 row", row_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_cfg(1, 2, 3, 4, 5, 6, 7, 8, 32'h8888_8888, 1, 1);
    run_cfg(2, 4, 4, 8, 9, 9, 9, 20, 32'h0808_8080, 1, 2);
    run_cfg(0, 0, 0, 5, 5, 10, 10, 255, 32'h8800_0088, 0, 3);
    run_cfg(0, 0, 0, 0, 0, 0, 0, 0, 32'hffff_ffff, 1, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule